// File: doc/BRIEF.md
# Timer Capture Register Bank

This block holds four 16-bit capture registers that each take a snapshot of a free-running timer value supplied from outside. Each register has its own trigger mode. In pin mode a register snapshots the timer when its capture pin shows the chosen transition. In software mode a register snapshots the timer one clock after software writes its low byte. Only pin-mode captures raise a per-register flag. Software can clear these flags.

Capture pins are asynchronous. They pass through a two-flop synchronizer and a one-flop edge detector before they can trigger a capture. Registers 0 to 2 react to rising edges only. Register 3 reacts to either edge, as chosen by a falling-edge select input. That input is registered before use. Software reads any register through a combinational readback port, and it writes the low or high byte of any register through a byte-wide write port. Both bytes of the timer value are always loaded in the same clock, so a captured value is never split across two timer states.

Top module: `capture_bank`

## Requirements
- R1: After reset, all four registers read 0, all flags are 0, and register 3 uses rising-edge capture.
- R2: With `cap_mode[i]`=0, a rising edge on `cap_pin[i]` (i = 0..2) loads the full 16-bit `timer_val` into register i. The value loaded is the one present at the third rising clock edge after the pin goes high.
- R3: A falling edge on `cap_pin[0..2]` never causes a capture.
- R4: With `fall_edge_sel`=0, register 3 captures on a rising edge of `cap_pin[3]`. With `fall_edge_sel`=1, it captures on a falling edge and ignores rising edges. The select input is registered once before it takes effect.
- R5: Every pin-mode capture sets bit i of `cap_flag`, with the same timing as the register update.
- R6: A cycle with `wr_flag`=1 clears each flag i whose `wr_data[i]` is 0 and leaves each flag whose bit is 1 unchanged. A capture in the same cycle sets the flag regardless of the clear.
- R7: With `cap_mode[i]`=1, a low-byte write (`wr_en`, `wr_lo`, `wr_addr`=i) stores the byte for one cycle. On the following clock edge the register loads `timer_val`.
- R8: Captures started by software never set a flag.
- R9: With `cap_mode[i]`=1, edges on `cap_pin[i]` cause no capture and no flag.
- R10: With `cap_mode[i]`=0, low-byte and high-byte writes store `wr_data` into bits 7:0 and 15:8 respectively, with no capture. A high-byte write never starts a capture in either mode.
- R11: When a capture and a byte write reach the same register on the same edge, the capture wins.
- R12: `rd_data` shows register `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_val | input | 16 | Timer value to snapshot |
| cap_pin | input | 4 | Asynchronous capture pins, one per register |
| fall_edge_sel | input | 1 | 1 selects falling-edge capture for register 3 |
| cap_mode | input | 4 | Per-register trigger mode: 0 pin, 1 software write |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 2 | Register index for byte writes |
| wr_lo | input | 1 | Write the low byte |
| wr_hi | input | 1 | Write the high byte |
| wr_flag | input | 1 | Flag write; zero bits of wr_data clear flags |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Readback register index |
| rd_data | output | 16 | Readback value |
| cap_flag | output | 4 | Capture flags |

## Verification
Each result has a fixed due cycle. A pin edge driven before clock edge k changes its register and flag at edge k+2, after two synchronizer stages and the edge detector. A software low-byte write at edge w shows the written byte after w and the timer value after w+1. Byte writes and flag writes take effect at the edge that samples them. The bench drives every stimulus on a falling clock edge and counts falling edges from that point. At each intermediate falling edge it checks that the old value is still present, and at the due falling edge it checks the new one. Each timer value is held at a distinct constant until the capture edge has passed, so a capture one cycle early or late shows up as a mismatch.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    typedef enum logic {
        TRIG_PIN = 1'b0,
        TRIG_SW  = 1'b1
    } trig_e;
endpackage

// File: rtl/cap_sync.sv
// Pin synchronizer followed by a one-flop edge detector.
module cap_sync #(
    parameter int STAGES     = 2,
    parameter bit SELECTABLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t q, d;
    logic  rise, fall;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], pin};
        d.prev = q.sync[STAGES-1];
        rise   = q.sync[STAGES-1] & ~q.prev;
        fall   = ~q.sync[STAGES-1] & q.prev;
        evt    = (SELECTABLE && (fall_sel == cap_pkg::EDGE_FALL)) ? fall : rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cap_slot.sv
// One capture register: pin or software trigger, byte writes.
module cap_slot #(
    parameter int BYTE_W = 8,
    localparam int TW    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sw,
    input  logic              pin_evt,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [TW-1:0]     timer,
    output logic [TW-1:0]     value,
    output logic              hw_cap
);
    typedef struct packed {
        logic [TW-1:0] val;
        logic          pend;
    } slot_t;

    slot_t q, d;
    logic  capture;

    always_comb begin
        d       = q;
        hw_cap  = pin_evt & (mode_sw == cap_pkg::TRIG_PIN);
        capture = hw_cap | q.pend;
        d.pend  = wr_lo & (mode_sw == cap_pkg::TRIG_SW);
        if (capture) begin
            d.val = timer;
        end else begin
            if (wr_lo) d.val[BYTE_W-1:0]  = wr_byte;
            if (wr_hi) d.val[TW-1:BYTE_W] = wr_byte;
        end
        value = q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/capture_bank.sv
module capture_bank #(
    parameter int BYTE_W      = 8,
    parameter int NREG        = 4,
    parameter int SYNC_STAGES = 2,
    localparam int TW         = 2 * BYTE_W,
    localparam int AW         = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_val,
    input  logic [NREG-1:0]   cap_pin,
    input  logic              fall_edge_sel,
    input  logic [NREG-1:0]   cap_mode,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_flag,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [TW-1:0]     rd_data,
    output logic [NREG-1:0]   cap_flag
);
    typedef struct packed {
        logic [NREG-1:0] flag;
        logic            edge_f;
    } ctl_t;

    ctl_t q, d;

    logic [NREG-1:0]         pin_evt;
    logic [NREG-1:0]         hw_evt;
    logic [NREG-1:0][TW-1:0] slot_val;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(i));

        cap_sync #(
            .STAGES    (SYNC_STAGES),
            .SELECTABLE(i == NREG - 1)
        ) i_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (cap_pin[i]),
            .fall_sel(q.edge_f),
            .evt     (pin_evt[i])
        );

        cap_slot #(
            .BYTE_W(BYTE_W)
        ) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_sw(cap_mode[i]),
            .pin_evt(pin_evt[i]),
            .wr_lo  (sel & wr_lo),
            .wr_hi  (sel & wr_hi),
            .wr_byte(wr_data),
            .timer  (timer_val),
            .value  (slot_val[i]),
            .hw_cap (hw_evt[i])
        );
    end

    always_comb begin
        d        = q;
        d.edge_f = fall_edge_sel;
        for (int i = 0; i < NREG; i++) begin
            if (wr_flag && !wr_data[i]) d.flag[i] = 1'b0;
            if (hw_evt[i])              d.flag[i] = 1'b1;
        end
        rd_data  = slot_val[rd_addr];
        cap_flag = q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{flag: '0, edge_f: cap_pkg::EDGE_RISE};
        else        q <= d;
    end
endmodule

// File: rtl/cap_bank_chk.sv
module cap_bank_chk #(
    parameter int NREG   = 4,
    parameter int TW     = 16,
    parameter int AW     = 2,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [TW-1:0]           timer_val,
    input logic [NREG-1:0]         cap_mode,
    input logic                    wr_en,
    input logic [AW-1:0]           wr_addr,
    input logic                    wr_lo,
    input logic                    wr_hi,
    input logic                    wr_flag,
    input logic [BYTE_W-1:0]       wr_data,
    input logic [NREG-1:0]         cap_flag,
    input logic [NREG-1:0]         pin_evt,
    input logic [NREG-1:0][TW-1:0] slot_val
);
    for (genvar i = 0; i < NREG; i++) begin : g_chk
        AST_SW_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(cap_flag[i]) |-> !$past(cap_mode[i])); // R8
        AST_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cap_flag[i]) |-> $past(pin_evt[i])); // R5
        AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(cap_flag[i]) |-> $past(wr_flag && !wr_data[i])); // R6
        AST_SW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_lo && wr_addr == AW'(i) && cap_mode[i]) |=> ##1 (slot_val[i] == $past(timer_val))); // R7
        AST_VALUE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(slot_val[i]) |-> ($past(pin_evt[i] || (wr_en && (wr_lo || wr_hi) && wr_addr == AW'(i))) || $past(wr_en && wr_lo && wr_addr == AW'(i) && cap_mode[i], 2))); // R10
    end
endmodule

bind capture_bank cap_bank_chk #(
    .NREG  (NREG),
    .TW    (TW),
    .AW    (AW),
    .BYTE_W(BYTE_W)
) i_cap_bank_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .timer_val(timer_val),
    .cap_mode (cap_mode),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_flag  (wr_flag),
    .wr_data  (wr_data),
    .cap_flag (cap_flag),
    .pin_evt  (pin_evt),
    .slot_val (slot_val)
);

// File: tb/test_capture_bank.sv
module test_capture_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic [3:0]  cap_pin = '0;
    logic        fall_edge_sel = 1'b0;
    logic [3:0]  cap_mode = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic        wr_flag = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [3:0]  cap_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    capture_bank i_capture_bank (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_pin(cap_pin),
        .fall_edge_sel(fall_edge_sel), .cap_mode(cap_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_flag(wr_flag),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cap_flag(cap_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input int idx, input logic [15:0] exp, input string req);
        rd_addr = 2'(idx);
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic read_reg(input int idx, output logic [15:0] v);
        rd_addr = 2'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic clear_flag(input int idx);
        @(negedge clk);
        wr_flag = 1'b1;
        wr_data = ~(8'h01 << idx);
        @(negedge clk);
        wr_flag = 1'b0;
        wr_data = '0;
        #1;
        check("R6 flag cleared", 16'(cap_flag[idx]), 16'h0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) rd_chk(i, 16'h0, "R1 R12 reset value");
        check("R1 reset flags", 16'(cap_flag), 16'h0);
    endtask

    task automatic t_pin_rise(input int i);
        logic [15:0] old;
        @(negedge clk);
        read_reg(i, old);
        timer_val = 16'hA000 + 16'(i);
        cap_pin[i] = 1'b1;
        @(negedge clk);
        rd_chk(i, old, "R2 no early capture");
        @(negedge clk);
        rd_chk(i, old, "R2 no early capture");
        check("R5 flag not early", 16'(cap_flag[i]), 16'h0);
        @(negedge clk);
        rd_chk(i, 16'hA000 + 16'(i), "R2 capture value");
        check("R5 flag set", 16'(cap_flag[i]), 16'h1);
        timer_val = 16'h0F0F;
        cap_pin[i] = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk(i, 16'hA000 + 16'(i), "R3 falling edge ignored");
        clear_flag(i);
    endtask

    task automatic t_edge_sel();
        logic [15:0] old;
        @(negedge clk);
        fall_edge_sel = 1'b1;
        repeat (2) @(negedge clk);
        read_reg(3, old);
        timer_val = 16'h3C3C;
        cap_pin[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk(3, old, "R4 rising ignored in falling mode");
        check("R4 no flag on rising", 16'(cap_flag[3]), 16'h0);
        timer_val = 16'h5A5A;
        cap_pin[3] = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk(3, old, "R4 no early capture");
        @(negedge clk);
        rd_chk(3, 16'h5A5A, "R4 falling capture");
        check("R4 flag on falling", 16'(cap_flag[3]), 16'h1);
        clear_flag(3);
        fall_edge_sel = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_sw_capture(input int i);
        logic [15:0] old;
        @(negedge clk);
        cap_mode[i] = 1'b1;
        read_reg(i, old);
        timer_val = 16'h7700 + 16'(i);
        wr_en = 1'b1; wr_addr = 2'(i); wr_lo = 1'b1; wr_data = 8'hC0 + 8'(i);
        @(negedge clk);
        wr_en = 1'b0; wr_lo = 1'b0; wr_data = '0;
        timer_val = 16'hBEE0 + 16'(i);
        rd_chk(i, {old[15:8], 8'hC0 + 8'(i)}, "R7 byte visible first");
        @(negedge clk);
        rd_chk(i, 16'hBEE0 + 16'(i), "R7 timer captured next cycle");
        timer_val = 16'h1234;
        @(negedge clk);
        check("R8 no flag from software capture", 16'(cap_flag[i]), 16'h0);
        cap_mode[i] = 1'b0;
    endtask

    task automatic t_sw_pin_ignored(input int i);
        logic [15:0] old;
        @(negedge clk);
        cap_mode[i] = 1'b1;
        read_reg(i, old);
        timer_val = 16'h9999;
        cap_pin[i] = 1'b1;
        repeat (5) @(negedge clk);
        rd_chk(i, old, "R9 pin ignored in software mode");
        check("R9 no flag", 16'(cap_flag[i]), 16'h0);
        cap_pin[i] = 1'b0;
        repeat (4) @(negedge clk);
        cap_mode[i] = 1'b0;
    endtask

    task automatic t_byte_writes(input int i);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(i); wr_lo = 1'b1; wr_data = 8'h34;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b1; wr_data = 8'h12;
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0;
        timer_val = 16'h4444;
        rd_chk(i, 16'h1234, "R10 byte writes stored");
        repeat (3) @(negedge clk);
        rd_chk(i, 16'h1234, "R10 no capture after pin-mode write");
        cap_mode[i] = 1'b1;
        wr_en = 1'b1; wr_hi = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0;
        rd_chk(i, 16'h7734, "R10 high byte stored in software mode");
        repeat (2) @(negedge clk);
        rd_chk(i, 16'h7734, "R10 high write starts no capture");
        cap_mode[i] = 1'b0;
    endtask

    task automatic t_priority(input int i);
        @(negedge clk);
        timer_val = 16'h4242;
        cap_pin[i] = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(i); wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; wr_data = '0;
        rd_chk(i, 16'h4242, "R11 capture beats write");
        cap_pin[i] = 1'b0;
        clear_flag(i);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < 4; i++) t_pin_rise(i);
        t_edge_sel();
        t_sw_capture(0);
        t_sw_capture(2);
        t_sw_pin_ignored(1);
        t_byte_writes(2);
        t_priority(0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule